// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags and Selectable Read Mode

The block is a first-in first-out buffer with a write port and a read port, each driven by its own clock. Words are kept in a storage array that can map to block RAM. Pointers cross between the two clock domains in Gray code. The write side reports full, half-full and a programmable almost-full level. The read side reports empty and a programmable almost-empty level. A master reset latches the read behaviour, the flag timing and the two level offsets. A partial reset clears the contents and keeps everything that master reset latched.

In standard mode a word leaves the buffer only on a read request. The read-side status pin then reports empty and the write-side status pin reports full. In fall-through mode the oldest word is placed on the output without a request and stays there until a read consumes it. The same two pins then report output-valid and room-available. The two level offsets come from a separate loader and are taken in while master reset is held. Both resets are synchronous and active high. Each must be held for at least three edges of both clocks.

Top module: `prog_flag_fifo`

## Requirements
- R1: The read mode is taken from `cfg_fwft` only while `mrst` is high (0 = standard, 1 = fall-through). In standard mode `rd_flag` is 1 when the buffer is empty and `wr_flag` is 1 when it is full. In fall-through mode `rd_flag` is 1 when a valid word is on `rd_data` and `wr_flag` is 1 when a write would be accepted.
- R2: In standard mode a read accepted at a read-clock edge puts the word on `rd_data` right after that edge. Without an accepted read, `rd_data` does not change.
- R3: In fall-through mode a word written into an empty buffer at write-clock edge k appears on `rd_data` after read-clock edge k+3. `rd_flag` rises after the same edge. The word is held until `rd_en` is high at an edge, which moves the next stored word to the output or drops `rd_flag`.
- R4: The read-side level is the number of stored words, counting the word on the output in fall-through mode. `almost_empty_n` is 1 when this level is at least the empty offset n and 0 when it is below n, for n in 1..DEPTH-1.
- R5: The write-side occupancy is the number of words written and not yet taken from the storage array. Capacity is therefore DEPTH words in standard mode and DEPTH+1 in fall-through mode. `almost_full_n` is 1 when DEPTH minus occupancy exceeds the full offset m and 0 when it is at most m, for m in 1..DEPTH-1.
- R6: `half_full` is 1 exactly when the write-side occupancy is greater than DEPTH/2.
- R7: With `cfg_flag_reg` = 0 latched, `almost_empty_n` and `almost_full_n` follow the pointer state directly. With 1 latched, they change one clock edge later.
- R8: Master reset empties the buffer, sets `rd_data` to zero and re-latches the mode, the flag timing and both offsets.
- R9: Partial reset empties the buffer and sets `rd_data` to zero. It keeps the latched mode, flag timing and offsets even if the configuration inputs have changed.
- R10: A write while full and a read while empty are ignored and leave the contents and the read data unchanged.
- R11: Pointers cross clock domains in Gray code, one bit changing per edge. A write at edge k clears the standard-mode empty flag after read edge k+2. A read at edge j clears the full flag after write edge j+2.
- R12: Words leave in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| mrst | input | 1 | Master reset, synchronous, active high, latches configuration |
| prst | input | 1 | Partial reset, synchronous, active high, keeps configuration |
| cfg_fwft | input | 1 | Read mode sampled at master reset: 0 standard, 1 fall-through |
| cfg_flag_reg | input | 1 | Level-flag timing sampled at master reset: 0 direct, 1 one extra edge |
| cfg_ae_off | input | log2(DEPTH) | Empty offset n, sampled at master reset |
| cfg_af_off | input | log2(DEPTH) | Full offset m, sampled at master reset |
| wr_en | input | 1 | Write request |
| wr_data | input | WIDTH | Write data |
| rd_en | input | 1 | Read request |
| rd_data | output | WIDTH | Read data |
| rd_flag | output | 1 | Empty (standard) or output-valid (fall-through) |
| wr_flag | output | 1 | Full (standard) or room-available (fall-through) |
| almost_empty_n | output | 1 | 0 when read-side level is below n |
| almost_full_n | output | 1 | 0 when free space is at most m |
| half_full | output | 1 | 1 when write-side occupancy exceeds DEPTH/2 |

## Verification
Some properties are checked on every cycle. Both Gray pointers change by at most one bit per edge. A write at full and a read at empty leave the pointers and the standard-mode data still. A valid fall-through word is held while no read is requested. Full always comes with almost-full asserted. The exact latencies cannot be seen by a single-cycle property: three cycles for fall-through, two for each flag crossing, and one more for registered flags. The scenarios also cover the level thresholds over every offset pair in both modes, and the retention of configuration across a partial reset, including data order at capacity.

// File: rtl/pff_pkg.sv
package pff_pkg;
  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/pff_sync2.sv
module pff_sync2 #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/pff_mem.sv
module pff_mem #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             wclk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             rclk,
  input  logic             rrst,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] store [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) store[waddr] <= wdata;
  end

  // output register doubles as the read-data register; sync reset clears it
  always_ff @(posedge rclk) begin
    if (rrst)    rdata <= '0;
    else if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/pff_wr_side.sv
module pff_wr_side
  import pff_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          mrst,
  input  logic          prst,
  input  logic          cfg_fwft,
  input  logic          cfg_flag_reg,
  input  logic [AW-1:0] cfg_af_off,
  input  logic          wr_en,
  input  logic [AW:0]   rgray_s,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wgray,
  output logic          full,
  output logic          fwft,
  output logic          almost_full_n,
  output logic          half_full
);
  localparam logic [AW:0] CAP  = (AW+1)'(DEPTH);
  localparam logic [AW:0] HALF = (AW+1)'(DEPTH / 2);

  logic          rst;
  rd_mode_e      mode_q;
  logic          freg_q;
  logic [AW-1:0] moff_q;
  logic [AW:0]   wbin, wnxt, rbin, occ, room;
  logic          af_raw, af_q;

  assign rst = mrst | prst;

  always_ff @(posedge clk) begin
    if (mrst) begin
      mode_q <= rd_mode_e'(cfg_fwft);
      freg_q <= cfg_flag_reg;
      moff_q <= cfg_af_off;
    end
  end

  always_comb begin
    rbin[AW] = rgray_s[AW];
    for (int i = AW - 1; i >= 0; i--) rbin[i] = rbin[i+1] ^ rgray_s[i];
  end

  assign occ    = wbin - rbin;
  assign room   = CAP - occ;
  assign full   = (occ == CAP);
  assign we     = wr_en & ~full;
  assign wnxt   = wbin + (AW+1)'(1);
  assign af_raw = room > {1'b0, moff_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      wbin  <= '0;
      wgray <= '0;
      af_q  <= 1'b1;
    end else begin
      if (we) begin
        wbin  <= wnxt;
        wgray <= wnxt ^ (wnxt >> 1);
      end
      af_q <= af_raw;
    end
  end

  assign waddr         = wbin[AW-1:0];
  assign fwft          = (mode_q == MODE_FWFT);
  assign almost_full_n = freg_q ? af_q : af_raw;
  assign half_full     = occ > HALF;
endmodule

// File: rtl/pff_rd_side.sv
module pff_rd_side
  import pff_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          mrst,
  input  logic          prst,
  input  logic          cfg_fwft,
  input  logic          cfg_flag_reg,
  input  logic [AW-1:0] cfg_ae_off,
  input  logic          rd_en,
  input  logic [AW:0]   wgray_s,
  output logic          re,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray,
  output logic          empty,
  output logic          fwft,
  output logic          ovalid,
  output logic          almost_empty_n
);
  logic          rst;
  rd_mode_e      mode_q;
  logic          freg_q;
  logic [AW-1:0] noff_q;
  logic [AW:0]   rbin, rnxt, wbin, avail, level;
  logic          ae_raw, ae_q;

  assign rst = mrst | prst;

  always_ff @(posedge clk) begin
    if (mrst) begin
      mode_q <= rd_mode_e'(cfg_fwft);
      freg_q <= cfg_flag_reg;
      noff_q <= cfg_ae_off;
    end
  end

  always_comb begin
    wbin[AW] = wgray_s[AW];
    for (int i = AW - 1; i >= 0; i--) wbin[i] = wbin[i+1] ^ wgray_s[i];
  end

  assign fwft  = (mode_q == MODE_FWFT);
  assign avail = wbin - rbin;
  assign empty = (avail == '0);
  // fall-through refills the output stage whenever it is free or being consumed
  assign re    = fwft ? (~empty & (~ovalid | rd_en)) : (rd_en & ~empty);
  assign rnxt  = rbin + (AW+1)'(1);
  assign level = avail + {{AW{1'b0}}, ovalid};
  assign ae_raw = level >= {1'b0, noff_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      rbin   <= '0;
      rgray  <= '0;
      ovalid <= 1'b0;
      ae_q   <= 1'b0;
    end else begin
      if (re) begin
        rbin  <= rnxt;
        rgray <= rnxt ^ (rnxt >> 1);
      end
      if (fwft) begin
        if (re)         ovalid <= 1'b1;
        else if (rd_en) ovalid <= 1'b0;
      end
      ae_q <= ae_raw;
    end
  end

  assign raddr          = rbin[AW-1:0];
  assign almost_empty_n = freg_q ? ae_q : ae_raw;
endmodule

// File: rtl/prog_flag_fifo.sv
module prog_flag_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8
) (
  input  logic                     wclk,
  input  logic                     rclk,
  input  logic                     mrst,
  input  logic                     prst,
  input  logic                     cfg_fwft,
  input  logic                     cfg_flag_reg,
  input  logic [$clog2(DEPTH)-1:0] cfg_ae_off,
  input  logic [$clog2(DEPTH)-1:0] cfg_af_off,
  input  logic                     wr_en,
  input  logic [WIDTH-1:0]         wr_data,
  input  logic                     rd_en,
  output logic [WIDTH-1:0]         rd_data,
  output logic                     rd_flag,
  output logic                     wr_flag,
  output logic                     almost_empty_n,
  output logic                     almost_full_n,
  output logic                     half_full
);
  localparam int AW = $clog2(DEPTH);

  logic          w_we, w_full, w_fwft;
  logic [AW-1:0] w_addr;
  logic [AW:0]   wgray, wgray_r;
  logic          r_re, r_empty, r_fwft, r_ovalid;
  logic [AW-1:0] r_addr;
  logic [AW:0]   rgray, rgray_w;
  logic          rrst;

  assign rrst = mrst | prst;

  pff_sync2 #(.W(AW + 1)) u_w2r (
    .clk(rclk), .rst(rrst), .d(wgray), .q(wgray_r)
  );

  pff_sync2 #(.W(AW + 1)) u_r2w (
    .clk(wclk), .rst(rrst), .d(rgray), .q(rgray_w)
  );

  pff_wr_side #(.DEPTH(DEPTH), .AW(AW)) u_wr (
    .clk(wclk), .mrst(mrst), .prst(prst),
    .cfg_fwft(cfg_fwft), .cfg_flag_reg(cfg_flag_reg), .cfg_af_off(cfg_af_off),
    .wr_en(wr_en), .rgray_s(rgray_w),
    .we(w_we), .waddr(w_addr), .wgray(wgray), .full(w_full), .fwft(w_fwft),
    .almost_full_n(almost_full_n), .half_full(half_full)
  );

  pff_rd_side #(.DEPTH(DEPTH), .AW(AW)) u_rd (
    .clk(rclk), .mrst(mrst), .prst(prst),
    .cfg_fwft(cfg_fwft), .cfg_flag_reg(cfg_flag_reg), .cfg_ae_off(cfg_ae_off),
    .rd_en(rd_en), .wgray_s(wgray_r),
    .re(r_re), .raddr(r_addr), .rgray(rgray), .empty(r_empty), .fwft(r_fwft),
    .ovalid(r_ovalid), .almost_empty_n(almost_empty_n)
  );

  pff_mem #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) u_mem (
    .wclk(wclk), .we(w_we), .waddr(w_addr), .wdata(wr_data),
    .rclk(rclk), .rrst(rrst), .re(r_re), .raddr(r_addr), .rdata(rd_data)
  );

  assign rd_flag = r_fwft ? r_ovalid : r_empty;
  assign wr_flag = w_fwft ? ~w_full : w_full;
endmodule

// File: rtl/pff_checker.sv
module pff_checker #(
  parameter int AW    = 4,
  parameter int WIDTH = 8
) (
  input logic             wclk,
  input logic             rclk,
  input logic             mrst,
  input logic             prst,
  input logic             wr_en,
  input logic             rd_en,
  input logic             w_full,
  input logic             r_empty,
  input logic             r_fwft,
  input logic             r_ovalid,
  input logic [AW:0]      wgray,
  input logic [AW:0]      rgray,
  input logic [WIDTH-1:0] rd_data,
  input logic             almost_full_n
);
  logic rst;
  assign rst = mrst | prst;

  AST_WGRAY_ONE_BIT: assert property (@(posedge wclk) disable iff (rst)
    !$past(rst) |-> $onehot0(wgray ^ $past(wgray))); // R11

  AST_RGRAY_ONE_BIT: assert property (@(posedge rclk) disable iff (rst)
    !$past(rst) |-> $onehot0(rgray ^ $past(rgray))); // R11

  AST_FULL_WRITE_IGNORED: assert property (@(posedge wclk) disable iff (rst)
    (w_full && wr_en) |=> $stable(wgray)); // R10

  AST_EMPTY_READ_IGNORED: assert property (@(posedge rclk) disable iff (rst)
    (r_empty && rd_en) |=> $stable(rgray)); // R10

  AST_STD_DATA_HELD: assert property (@(posedge rclk) disable iff (rst)
    (!r_fwft && !rd_en) |=> $stable(rd_data)); // R2

  AST_FWFT_WORD_HELD: assert property (@(posedge rclk) disable iff (rst)
    (r_fwft && r_ovalid && !rd_en) |=> (r_ovalid && $stable(rd_data))); // R3

  AST_FULL_IMPLIES_AF: assert property (@(posedge wclk) disable iff (rst)
    w_full |-> !almost_full_n); // R5
endmodule

bind prog_flag_fifo pff_checker #(.AW(AW), .WIDTH(WIDTH)) u_chk (
  .wclk(wclk), .rclk(rclk), .mrst(mrst), .prst(prst),
  .wr_en(wr_en), .rd_en(rd_en), .w_full(w_full), .r_empty(r_empty),
  .r_fwft(r_fwft), .r_ovalid(r_ovalid), .wgray(wgray), .rgray(rgray),
  .rd_data(rd_data), .almost_full_n(almost_full_n)
);

// File: tb/test_prog_flag_fifo.sv
module test_prog_flag_fifo;
  localparam int TCK   = 10;
  localparam int DEPTH = 8;
  localparam int WIDTH = 8;
  localparam int AW    = $clog2(DEPTH);

  logic clk = 1'b0;
  logic mrst = 1'b1, prst = 1'b0;
  logic cfg_fwft = 1'b0, cfg_flag_reg = 1'b0;
  logic [AW-1:0] cfg_ae_off = '0, cfg_af_off = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [WIDTH-1:0] wr_data = '0;
  logic [WIDTH-1:0] rd_data;
  logic rd_flag, wr_flag, almost_empty_n, almost_full_n, half_full;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(TCK/2) clk = ~clk;

  prog_flag_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_prog_flag_fifo (
    .wclk(clk), .rclk(clk), .mrst(mrst), .prst(prst),
    .cfg_fwft(cfg_fwft), .cfg_flag_reg(cfg_flag_reg),
    .cfg_ae_off(cfg_ae_off), .cfg_af_off(cfg_af_off),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .rd_flag(rd_flag), .wr_flag(wr_flag), .almost_empty_n(almost_empty_n),
    .almost_full_n(almost_full_n), .half_full(half_full)
  );

  task automatic expect_eq(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic master_reset(input bit fw, input bit fr, input int n, input int m);
    @(negedge clk);
    cfg_fwft = fw; cfg_flag_reg = fr;
    cfg_ae_off = AW'(n); cfg_af_off = AW'(m);
    mrst = 1'b1;
    idle(3);
    mrst = 1'b0;
  endtask

  task automatic push(input logic [WIDTH-1:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pop();
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic check_levels(input bit fw, input int n, input int m, input int l);
    int lw;
    lw = fw ? ((l > 0) ? l - 1 : 0) : l;
    expect_eq("R4 almost_empty_n", int'(almost_empty_n), int'(l >= n));
    expect_eq("R5 almost_full_n", int'(almost_full_n), int'((DEPTH - lw) > m));
    expect_eq("R6 half_full", int'(half_full), int'(lw > DEPTH / 2));
    expect_eq("R1 wr_flag", int'(wr_flag), fw ? int'(lw < DEPTH) : int'(lw == DEPTH));
    expect_eq("R1 rd_flag", int'(rd_flag), fw ? int'(l > 0) : int'(l == 0));
  endtask

  task automatic sweep(input bit fw, input int n, input int m);
    int lim;
    lim = fw ? DEPTH + 1 : DEPTH;
    master_reset(fw, 1'((n + m) % 2), n, m);
    for (int l = 0; l <= lim; l++) begin
      if (l > 0) push(WIDTH'(n * 16 + m + l));
      idle(8);
      check_levels(fw, n, m, l);
    end
    for (int l = lim; l > 0; l--) begin
      if (fw) expect_eq("R12 fwft order", int'(rd_data), n * 16 + m + lim - l + 1);
      pop();
      if (!fw) expect_eq("R12 std order", int'(rd_data), n * 16 + m + lim - l + 1);
      idle(8);
      check_levels(fw, n, m, l - 1);
    end
  endtask

  initial begin
    #(TCK * 100000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // reset state, standard mode (R8, R1)
    master_reset(1'b0, 1'b0, 2, 2);
    expect_eq("R8 rd_data zero", int'(rd_data), 0);
    expect_eq("R1 empty after reset", int'(rd_flag), 1);
    expect_eq("R1 not full after reset", int'(wr_flag), 0);
    expect_eq("R8 almost_empty_n", int'(almost_empty_n), 0);
    expect_eq("R8 almost_full_n", int'(almost_full_n), 1);
    expect_eq("R8 half_full", int'(half_full), 0);

    // crossing latency and standard read latency (R11, R2)
    push(8'h5A);
    expect_eq("R11 empty edge k", int'(rd_flag), 1);
    idle(1);
    expect_eq("R11 empty edge k+1", int'(rd_flag), 1);
    idle(1);
    expect_eq("R11 empty clears k+2", int'(rd_flag), 0);
    expect_eq("R2 no request no data", int'(rd_data), 0);
    pop();
    expect_eq("R2 data after read", int'(rd_data), 8'h5A);
    expect_eq("R2 empty after last read", int'(rd_flag), 1);
    push(8'h6B);
    idle(5);
    expect_eq("R2 data held without request", int'(rd_data), 8'h5A);
    pop();
    expect_eq("R2 second read", int'(rd_data), 8'h6B);

    // full, ignored write, read-to-full crossing, order, ignored read (R10, R11, R12)
    master_reset(1'b0, 1'b0, 1, 1);
    for (int i = 0; i < DEPTH; i++) push(WIDTH'(8'hA0 + i));
    expect_eq("R10 full flag", int'(wr_flag), 1);
    push(8'hEE);
    idle(8);
    expect_eq("R10 still full", int'(wr_flag), 1);
    pop();
    expect_eq("R12 first out", int'(rd_data), 8'hA0);
    expect_eq("R11 full edge j", int'(wr_flag), 1);
    idle(1);
    expect_eq("R11 full edge j+1", int'(wr_flag), 1);
    idle(1);
    expect_eq("R11 full clears j+2", int'(wr_flag), 0);
    for (int i = 1; i < DEPTH; i++) begin
      pop();
      expect_eq("R12 order", int'(rd_data), 8'hA0 + i);
    end
    idle(4);
    expect_eq("R10 extra write dropped", int'(rd_flag), 1);
    pop();
    expect_eq("R10 read at empty ignored", int'(rd_data), 8'hA7);
    push(8'h55);
    idle(4);
    pop();
    expect_eq("R10 pointers intact", int'(rd_data), 8'h55);
    idle(4);
    expect_eq("R10 empty again", int'(rd_flag), 1);

    // fall-through latency and hold (R3)
    master_reset(1'b1, 1'b0, 1, 1);
    push(8'h3C);
    expect_eq("R3 not valid k", int'(rd_flag), 0);
    idle(1);
    expect_eq("R3 not valid k+1", int'(rd_flag), 0);
    idle(1);
    expect_eq("R3 not valid k+2", int'(rd_flag), 0);
    idle(1);
    expect_eq("R3 valid k+3", int'(rd_flag), 1);
    expect_eq("R3 data k+3", int'(rd_data), 8'h3C);
    push(8'h4D);
    idle(4);
    expect_eq("R3 held without read", int'(rd_data), 8'h3C);
    pop();
    expect_eq("R3 next word", int'(rd_data), 8'h4D);
    expect_eq("R3 still valid", int'(rd_flag), 1);
    pop();
    expect_eq("R3 valid drops", int'(rd_flag), 0);

    // flag timing select (R7)
    master_reset(1'b0, 1'b0, 1, 4);
    push(8'h11);
    idle(2);
    expect_eq("R7 direct flag at k+2", int'(almost_empty_n), 1);
    master_reset(1'b0, 1'b1, 1, 4);
    push(8'h11);
    idle(2);
    expect_eq("R7 registered flag at k+2", int'(almost_empty_n), 0);
    idle(1);
    expect_eq("R7 registered flag at k+3", int'(almost_empty_n), 1);

    // partial reset keeps configuration, master reset re-latches (R9, R8)
    master_reset(1'b1, 1'b0, 3, 2);
    push(8'h21); push(8'h22); push(8'h23);
    idle(8);
    @(negedge clk);
    cfg_fwft = 1'b0; cfg_ae_off = AW'(6); cfg_af_off = AW'(6);
    prst = 1'b1;
    idle(3);
    prst = 1'b0;
    expect_eq("R9 rd_data cleared", int'(rd_data), 0);
    expect_eq("R9 mode kept rd_flag", int'(rd_flag), 0);
    expect_eq("R9 mode kept wr_flag", int'(wr_flag), 1);
    expect_eq("R9 emptied", int'(almost_empty_n), 0);
    push(8'h31); push(8'h32); push(8'h33);
    idle(8);
    expect_eq("R9 fall-through kept", int'(rd_flag), 1);
    expect_eq("R9 first word after prst", int'(rd_data), 8'h31);
    expect_eq("R9 empty offset kept", int'(almost_empty_n), 1);
    expect_eq("R9 full offset kept", int'(almost_full_n), 1);
    master_reset(1'b0, 1'b0, 6, 6);
    expect_eq("R8 rd_data cleared", int'(rd_data), 0);
    expect_eq("R8 mode relatched rd_flag", int'(rd_flag), 1);
    expect_eq("R8 mode relatched wr_flag", int'(wr_flag), 0);

    // level sweep over all offset pairs, both modes (R1, R4, R5, R6, R12)
    for (int fw = 0; fw < 2; fw++)
      for (int n = 1; n < DEPTH; n++)
        for (int m = 1; m < DEPTH; m++)
          sweep(1'(fw), n, m);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule